// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits (32 by default) over several clock cycles and produces a result twice as wide. A pulse on `start` captures the multiplicand into a fixed register. The same pulse places the multiplier in the low half of a single double-width product register, and clears the high half and the carry.

Each following clock performs one step. If the product register's least significant bit is 1, the multiplicand is added into the high half; if it is 0, nothing is added. The whole register then shifts right by one place, and the adder's carry-out enters at the top. Multiplier bits are consumed from the bottom as product bits fill in from the top.

After exactly `WIDTH` steps, `busy` falls and `done` pulses for one cycle. `hi` and `lo` then hold the upper and lower halves of the product. `fits` reports whether the product can be represented in `WIDTH` bits. No trap is raised for a wide result.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0, `hi` and `lo` are 0, and `fits` is 1.
- R2: A `start` pulse seen at a clock edge while `busy` is 0 is accepted, and `busy` is 1 in the following cycle.
- R3: An accepted start is followed by exactly `WIDTH` cycles with `busy` at 1. `done` is 1 for exactly one cycle: the first cycle with `busy` back at 0.
- R4: When `done` is 1, `{hi, lo}` equals the unsigned product of the `op_a` and `op_b` values captured at the accepted start. `hi` is the upper half and `lo` is the lower half.
- R5: When `done` is 1, `fits` is 1 exactly when the product is below 2^`WIDTH`, that is, when `hi` is all zeros.
- R6: A `start` pulse while `busy` is 1 is ignored. It changes neither the result nor the length of the run in progress.
- R7: While `busy` is 0, `hi` and `lo` stay unchanged until the next accepted start.
- R8: Changes on `op_a` and `op_b` while `busy` is 1 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| op_a | input | WIDTH | Multiplicand |
| op_b | input | WIDTH | Multiplier |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| hi | output | WIDTH | Upper half of the product |
| lo | output | WIDTH | Lower half of the product |
| fits | output | 1 | Product is representable in WIDTH bits |

## Verification
The bench builds the block with the default `WIDTH` of 32. With that width, a 64-bit unsigned bench reference covers every product exactly. The 5-bit step counter must decode its last value, 31, to end the run. All-ones operands force a carry-out of the adder on nearly every step, which exercises the carry entering at the top of the register. Operands such as 0xFFFF times 0x10001 and 2^16 times 2^16 sit on either side of the boundary where `fits` changes, and random runs that wiggle the operands and re-pulse `start` mid-run reach the ignore and capture rules.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;

    typedef struct packed {
        logic busy;
        logic done;
    } run_flags_t;

endpackage

// File: rtl/mulseq_ctrl.sv
module mulseq_ctrl #(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    import mulseq_pkg::*;

    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    typedef struct packed {
        run_flags_t   flags;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  load_d;

    always_comb begin
        st_d            = st_q;
        st_d.flags.done = 1'b0;
        load_d          = 1'b0;
        if (!st_q.flags.busy) begin
            if (start) begin
                st_d.flags.busy = 1'b1;
                st_d.cnt        = '0;
                load_d          = 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.flags.busy = 1'b0;
                st_d.flags.done = 1'b1;
                st_d.cnt        = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load = load_d;
    assign step = st_q.flags.busy;
    assign busy = st_q.flags.busy;
    assign done = st_q.flags.done;

endmodule

// File: rtl/mulseq_datapath.sv
module mulseq_datapath #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic [2*WIDTH-1:0] prod
);
    localparam int PW = 2 * WIDTH;

    typedef struct packed {
        logic [PW-1:0]    prod;
        logic [WIDTH-1:0] mcand;
    } dp_t;

    dp_t            dp_d, dp_q;
    logic [WIDTH:0] sum_d;
    logic [WIDTH:0] addend_d;

    always_comb begin
        dp_d     = dp_q;
        addend_d = dp_q.prod[0] ? {1'b0, dp_q.mcand} : '0;
        sum_d    = {1'b0, dp_q.prod[PW-1:WIDTH]} + addend_d;
        if (load) begin
            dp_d.mcand = mcand_in;
            dp_d.prod  = {{WIDTH{1'b0}}, mplier_in};
        end else if (step) begin
            dp_d.prod = {sum_d, dp_q.prod[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign prod = dp_q.prod;

endmodule

// File: rtl/mulseq_fit.sv
module mulseq_fit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] upper,
    output logic             fits
);
    always_comb begin
        fits = ~(|upper);
    end

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo,
    output logic             fits
);
    logic               load_w;
    logic               step_w;
    logic [2*WIDTH-1:0] prod_w;

    mulseq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load_w),
        .step  (step_w),
        .busy  (busy),
        .done  (done)
    );

    mulseq_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_w),
        .step      (step_w),
        .mcand_in  (op_a),
        .mplier_in (op_b),
        .prod      (prod_w)
    );

    assign hi = prod_w[2*WIDTH-1:WIDTH];
    assign lo = prod_w[WIDTH-1:0];

    mulseq_fit #(.WIDTH(WIDTH)) u_fit (
        .upper (hi),
        .fits  (fits)
    );

endmodule

// File: rtl/mulseq_checker.sv
module mulseq_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] hi,
    input logic [WIDTH-1:0] lo,
    input logic             fits
);
    localparam int RW = $clog2(WIDTH + 2);

    logic [WIDTH-1:0]   a_l, b_l;
    logic [RW-1:0]      run_len;
    logic [2*WIDTH-1:0] ref_prod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_l     <= '0;
            b_l     <= '0;
            run_len <= '0;
        end else if (start && !busy) begin
            a_l     <= op_a;
            b_l     <= op_b;
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end
    end

    always_comb begin
        ref_prod = {{WIDTH{1'b0}}, a_l} * {{WIDTH{1'b0}}, b_l};
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_run_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && run_len == RW'(WIDTH)));

    p_end_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_product_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ({hi, lo} == ref_prod));

    p_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fits == ((ref_prod >> WIDTH) == '0)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({hi, lo}));

endmodule

bind shift_add_mul mulseq_checker #(.WIDTH(WIDTH)) u_mulseq_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .op_a  (op_a),
    .op_b  (op_b),
    .busy  (busy),
    .done  (done),
    .hi    (hi),
    .lo    (lo),
    .fits  (fits)
);

// File: tb/shift_add_mul_bench.sv
module shift_add_mul_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         busy, done, fits;
    logic [W-1:0] hi, lo;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    shift_add_mul #(.WIDTH(W)) u_shift_add_mul (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .hi(hi), .lo(lo), .fits(fits)
    );

    function automatic longint unsigned ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        longint unsigned x, y;
        x = longint'(a);
        y = longint'(b);
        return x * y;
    endfunction

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    // disturb: 1 = wiggle operands and re-pulse start during the run (R6, R8)
    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb);
        longint unsigned exp;
        int n;
        bit seen_done;
        exp = ref_mul(a, b);
        @(negedge clk);
        start = 1'b1;
        op_a  = a;
        op_b  = b;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", longint'(busy), 1);
        n = busy ? 1 : 0;
        seen_done = 0;
        for (int i = 0; i < 100; i++) begin
            if (disturb) begin
                op_a  = $urandom;
                op_b  = $urandom;
                start = (i == 10 || i == 20);
            end
            @(negedge clk);
            if (done) begin
                seen_done = 1;
                break;
            end
            if (busy) n++;
        end
        start = 1'b0;
        check("R3 busy cycles", longint'(n), W);
        check("R3 done seen", longint'(seen_done), 1);
        check("R4 product", {hi, lo}, exp);
        check("R5 fits", longint'(fits), longint'((exp >> W) == 0));
        @(negedge clk);
        check("R3 done one cycle", longint'(done), 0);
        check("R7 result held", {hi, lo}, exp);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        summary();
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", longint'(busy), 0);
        check("R1 done", longint'(done), 0);
        check("R1 hi lo", {hi, lo}, 0);
        check("R1 fits", longint'(fits), 1);
        rst_n = 1'b1;
        @(negedge clk);

        run(32'd0, 32'd0, 0);
        run(32'd0, 32'hFFFF_FFFF, 0);
        run(32'hFFFF_FFFF, 32'd0, 0);
        run(32'd1, 32'd1, 0);
        run(32'd1, 32'hDEAD_BEEF, 0);
        run(32'hFFFF_FFFF, 32'd1, 0);
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
        run(32'h0001_0000, 32'h0001_0000, 0);
        run(32'h0000_FFFF, 32'h0001_0001, 0);
        run(32'h8000_0000, 32'd2, 1);

        // R7: idle with no start keeps the previous result
        repeat (5) @(negedge clk);
        check("R7 idle hold", {hi, lo}, ref_mul(32'h8000_0000, 32'd2));

        for (int k = 0; k < 300; k++) begin
            logic [W-1:0] a, b;
            a = $urandom;
            b = $urandom;
            if (k % 4 == 1) b = b & 32'h0000_00FF;
            if (k % 4 == 2) a = a & 32'h0000_FFFF;
            run(a, b, (k % 3) == 0);
        end
        summary();
    end

endmodule